// File: doc/BRIEF.md
# Digit-Serial Decimal Word Adder

This block adds two packed decimal floating-point words, one 4-bit BCD digit per clock, least significant digit first. A word is 16 digits (64 bits). Positions 0 and 1 carry the exponent, positions 2 to 14 carry a 13-digit mantissa, and position 15 is a single digit that packs both sign flags. Only the mantissa digits are added. The block corrects each digit sum to decimal and ripples the decimal carry from one clock to the next. Exponent and sign digits are passed through from operand A. Aligning operands, normalizing, mixed-sign handling and subtraction are left to the surrounding datapath.

A caller pulses `start_i` in the same cycle as digit 0 of both operands and presents digits 1 to 15 on the next 15 cycles. Each result digit appears one clock after its operand digits. A one-cycle `done_o` marks the last digit, and `ovf_o` reports a carry out of the top mantissa digit.

Top module: `bcd_word_adder`

## Requirements
- R1: When `start_i` is high, the operand digits on the inputs are digit 0 of a word, and digits 1 to 15 follow on the next 15 consecutive cycles. The result digit for each input digit appears on `sum_digit_o`, with `out_valid_o` high, exactly one clock later.
- R2: For digit positions 0, 1 (exponent) and 15 (sign), the output digit equals the digit of operand A at that position, whatever the B digit and the carry state.
- R3: For digit positions 2 to 14 (mantissa), the output digit is (A + B + carry_in) mod 10. The carry to the next position is 1 when A + B + carry_in exceeds 9. For BCD inputs, the output is never above 9.
- R4: The mantissa carry chain starts from zero on every word. Exponent digits never produce a carry into position 2, even when their sum exceeds 9.
- R5: A carry out of position 14 is not added into the sign digit. The sign digit is still copied from A.
- R6: `ovf_o` is set one clock after position 14 when that position produces a carry, and is cleared otherwise. It holds its value until the cycle after the next `start_i`, and a `start_i` clears it to 0.
- R7: `done_o` is high for exactly one cycle: the cycle in which the result for position 15 is on `sum_digit_o`.
- R8: A `start_i` pulse during a word in progress abandons that word. The position count restarts at 0 and the carry is cleared, so the new word's result matches a fresh addition.
- R9: After reset, and whenever no word is in progress, `out_valid_o` and `done_o` are 0 and `sum_digit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks digit 0 of a new word on the operand inputs |
| a_digit_i | input | 4 | Operand A digit, least significant first |
| b_digit_i | input | 4 | Operand B digit, least significant first |
| sum_digit_o | output | 4 | Result digit, one clock after its inputs |
| out_valid_o | output | 1 | Result digit is valid |
| done_o | output | 1 | Result digit is position 15, the last of the word |
| ovf_o | output | 1 | Carry out of the top mantissa digit of the last word |

## Verification
The embedded assertions check the following on every cycle:
- exponent and sign digits are copied from operand A;
- mantissa digits stay in decimal range for BCD inputs;
- `done_o` is a lone pulse and coincides with a valid digit;
- the overflow flag changes only at position 14 or on a start;
- the sequencer returns to idle after position 15 and restarts cleanly.

The bench's scenarios cover what a single-cycle property cannot see. This includes carry rippling across all thirteen mantissa digits, an exponent sum above 9 that must not leak into the mantissa, and a mantissa overflow that must not reach the sign digit. It also covers back-to-back words, a word abandoned halfway, and a comparison of whole result words against an integer addition.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;

  typedef enum logic [1:0] {
    FLD_EXP  = 2'd0,
    FLD_MANT = 2'd1,
    FLD_SIGN = 2'd2
  } field_e;

  // exponent digits sit lowest, mantissa above, sign digit on top
  function automatic field_e field_of(int unsigned pos, int unsigned exp_digits,
                                      int unsigned mant_digits);
    if (pos < exp_digits) return FLD_EXP;
    if (pos < exp_digits + mant_digits) return FLD_MANT;
    return FLD_SIGN;
  endfunction

endpackage

// File: rtl/digit_sequencer.sv
module digit_sequencer #(
  parameter int unsigned DIGITS = 16,
  localparam int unsigned CNT_W = $clog2(DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] pos_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign valid_o = start_i | active_q;
  assign pos_o   = start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R9: word ends after the last position
  a_r9_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q == LAST && !start_i) |=> !active_q);

  // R8: a start always lands on position 1 next, unless restarted again
  a_r8_restart_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (start_i || (valid_o && pos_o == CNT_W'(1))));

endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add #(
  parameter int unsigned DW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);

  logic [DW:0] raw;
  logic [DW:0] adj;

  always_comb begin
    raw    = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
    cout_o = raw > (DW + 1)'(9);
    adj    = raw + (DW + 1)'(6);
    sum_o  = cout_o ? adj[DW-1:0] : raw[DW-1:0];
  end

endmodule

// File: rtl/field_select.sv
module field_select
  import bcd_adder_pkg::*;
#(
  parameter int unsigned DIGITS      = 16,
  parameter int unsigned EXP_DIGITS  = 2,
  parameter int unsigned MANT_DIGITS = 13,
  localparam int unsigned CNT_W      = $clog2(DIGITS)
) (
  input  logic [CNT_W-1:0] pos_i,
  output field_e           field_o,
  output logic             in_mant_o,
  output logic             mant_top_o
);

  localparam int unsigned MANT_HI = EXP_DIGITS + MANT_DIGITS - 1;

  always_comb begin
    field_o    = field_of(32'(pos_i), EXP_DIGITS, MANT_DIGITS);
    in_mant_o  = field_o == FLD_MANT;
    mant_top_o = 32'(pos_i) == MANT_HI;
  end

endmodule

// File: rtl/bcd_word_adder.sv
module bcd_word_adder
  import bcd_adder_pkg::*;
#(
  parameter int unsigned DIGITS      = 16,
  parameter int unsigned DW          = 4,
  parameter int unsigned EXP_DIGITS  = 2,
  parameter int unsigned MANT_DIGITS = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] a_digit_i,
  input  logic [DW-1:0] b_digit_i,
  output logic [DW-1:0] sum_digit_o,
  output logic          out_valid_o,
  output logic          done_o,
  output logic          ovf_o
);

  localparam int unsigned CNT_W = $clog2(DIGITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);

  logic             valid;
  logic [CNT_W-1:0] pos;
  field_e           field;
  logic             in_mant, mant_top;
  logic             carry_q, carry_in;
  logic [DW-1:0]    add_sum;
  logic             add_cout;
  logic [DW-1:0]    digit_d;

  logic [DW-1:0] sum_q;
  logic          valid_q, done_q, ovf_q;

  digit_sequencer #(.DIGITS(DIGITS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_o (valid),
    .pos_o   (pos)
  );

  field_select #(
    .DIGITS      (DIGITS),
    .EXP_DIGITS  (EXP_DIGITS),
    .MANT_DIGITS (MANT_DIGITS)
  ) u_field (
    .pos_i      (pos),
    .field_o    (field),
    .in_mant_o  (in_mant),
    .mant_top_o (mant_top)
  );

  // carry never survives into a new word
  assign carry_in = start_i ? 1'b0 : carry_q;

  bcd_digit_add #(.DW(DW)) u_add (
    .a_i    (a_digit_i),
    .b_i    (b_digit_i),
    .cin_i  (carry_in),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  assign digit_d = in_mant ? add_sum : a_digit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      sum_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      carry_q <= valid & in_mant & add_cout;
      sum_q   <= valid ? digit_d : '0;
      valid_q <= valid;
      done_q  <= valid && pos == LAST;
      if (valid && mant_top) ovf_q <= add_cout;
      else if (start_i)      ovf_q <= 1'b0;
    end
  end

  assign sum_digit_o = sum_q;
  assign out_valid_o = valid_q;
  assign done_o      = done_q;
  assign ovf_o       = ovf_q;

  a_r2_copy_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && field != FLD_MANT) |=> sum_digit_o == $past(a_digit_i));

  a_r3_bcd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && field == FLD_MANT && a_digit_i <= DW'(9) && b_digit_i <= DW'(9))
      |=> sum_digit_o <= DW'(9));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o);

  a_r6_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !(valid && mant_top)) |=> $stable(ovf_o));

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |=> (!out_valid_o && sum_digit_o == '0));

endmodule

// File: tb/bcd_word_adder_tb.sv
module bcd_word_adder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] a_d = '0, b_d = '0;
  logic [3:0] sum_digit;
  logic       out_valid, done, ovf;

  always #10 clk = ~clk;

  bcd_word_adder u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .a_digit_i   (a_d),
    .b_digit_i   (b_d),
    .sum_digit_o (sum_digit),
    .out_valid_o (out_valid),
    .done_o      (done),
    .ovf_o       (ovf)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model state
  bit         m_active = 0, m_carry = 0, m_ovf = 0;
  int         m_pos = 0;
  bit         have_exp = 0, e_valid = 0, e_done = 0;
  logic [3:0] e_sum = '0;
  int         e_pos = 0;
  logic [63:0] got_word = '0;
  string      scen = "R1";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string st;
    if (!have_exp) return;
    chk(out_valid == e_valid, {"R1/", scen}, "out_valid", out_valid, e_valid);
    chk(done == e_done, {"R7/", scen}, "done", done, e_done);
    chk(ovf == m_ovf, {"R6/", scen}, "ovf", ovf, m_ovf);
    if (!e_valid) st = "R9";
    else if (e_pos < 2 || e_pos == 15) st = "R2";
    else st = "R3";
    chk(sum_digit == e_sum, {st, "/", scen}, $sformatf("digit pos %0d", e_pos),
        sum_digit, e_sum);
    if (e_valid) got_word[4*e_pos +: 4] = sum_digit;
  endtask

  task automatic step(bit st, logic [3:0] a, logic [3:0] b);
    bit v;
    int p, s;
    @(negedge clk);
    compare();
    start = st; a_d = a; b_d = b;
    v = st || m_active;
    p = st ? 0 : m_pos;
    if (st) m_carry = 0;
    if (v) begin
      if (p >= 2 && p <= 14) begin
        s = int'(a) + int'(b) + int'(m_carry);
        m_carry = s > 9;
        e_sum = 4'(m_carry ? s - 10 : s);
        if (p == 14) m_ovf = m_carry;
      end else begin
        e_sum = a;
        m_carry = 0;
        if (st) m_ovf = 0;
      end
      e_done = p == 15;
      m_active = p < 15;
      m_pos = p + 1;
    end else begin
      e_sum = '0;
      e_done = 0;
    end
    e_valid = v;
    e_pos = p;
    have_exp = 1;
  endtask

  task automatic run_word(logic [63:0] a, logic [63:0] b, int cut);
    for (int i = 0; i < cut; i++) step(i == 0, a[4*i +: 4], b[4*i +: 4]);
  endtask

  function automatic logic [63:0] ref_word(logic [63:0] a, logic [63:0] b, output bit ov);
    longint ma = 0, mb = 0, s;
    logic [63:0] w;
    for (int i = 14; i >= 2; i--) begin
      ma = ma * 10 + longint'(a[4*i +: 4]);
      mb = mb * 10 + longint'(b[4*i +: 4]);
    end
    s = ma + mb;
    ov = s >= 64'd10000000000000;
    if (ov) s = s - 64'd10000000000000;
    w = a;
    for (int i = 2; i <= 14; i++) begin
      w[4*i +: 4] = 4'(s % 10);
      s = s / 10;
    end
    return w;
  endfunction

  task automatic add_word(string tag, logic [63:0] a, logic [63:0] b);
    logic [63:0] w;
    bit ov;
    scen = tag;
    run_word(a, b, 16);
    step(0, 0, 0);
    w = ref_word(a, b, ov);
    chk(got_word == w, tag, "word", got_word, w);
    chk(ovf == ov, {"R6/", tag}, "word ovf", ovf, ov);
  endtask

  initial begin
    logic [63:0] ra, rb;
    @(negedge clk); @(negedge clk);
    chk(out_valid == 0 && done == 0 && ovf == 0 && sum_digit == 0, "R9", "reset state",
        {out_valid, done, ovf, sum_digit}, 0);
    rst_n = 1'b1;
    step(0, 0, 0);

    add_word("R3", 64'h0_0000000000123_05, 64'h0_0000000000456_07);
    add_word("R3", 64'h0_0999999999999_12, 64'h0_0000000000001_34);
    add_word("R5", 64'h5_9999999999999_42, 64'h3_0000000000001_17);
    chk(ovf == 1, "R6", "ovf held idle", ovf, 1);
    step(0, 0, 0);
    chk(ovf == 1 && out_valid == 0, "R6", "ovf held, idle", {ovf, out_valid}, 2'b10);
    add_word("R4", 64'h0_0000000000000_99, 64'h0_0000000000000_99);
    chk(got_word[11:8] == 4'h0, "R4", "no exp carry into mantissa", got_word[11:8], 0);

    // back-to-back words
    scen = "R1";
    run_word(64'h1_0000000000909_01, 64'h2_0000000000191_02, 16);
    add_word("R1", 64'h7_4444444444444_55, 64'h8_5555555555556_66);

    // abandoned word then restart mid-stream
    scen = "R8";
    run_word(64'h0_9999999999999_99, 64'h0_9999999999999_99, 7);
    add_word("R8", 64'h0_0000000000001_00, 64'h0_0000000000002_00);

    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 16; i++) begin
        ra[4*i +: 4] = 4'($urandom_range(9));
        rb[4*i +: 4] = 4'($urandom_range(9));
      end
      add_word("R3", ra, rb);
    end

    step(0, 0, 0);
    step(0, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule